// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

This peripheral holds two independent down-counters behind a small register bus: an address, a write strobe, write data and combinational read data. A single control word holds a run bit and an auto-reload bit for each counter. Each counter also has a reload register and a live count register. Software can read and write both of them. An enabled counter steps down by one on every clock. When it reaches zero it either takes the reload value and carries on (periodic) or stops and clears its own run bit (one-shot).

Each counter has a sticky expiry flag that drives its own interrupt pin. Software clears a flag by writing a one to it. When counter 0 is loaded with all ones and auto-reload is on, it runs freely and wraps every 2^32 clocks. Software gets elapsed time by inverting the value it reads.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: Register offsets are as follows. Control is at 0x00: bit 0 is the timer 0 run bit, bit 1 is the timer 0 auto-reload bit, bit 2 is the timer 1 run bit and bit 3 is the timer 1 auto-reload bit. Upper control bits read zero. Interrupt status is at 0x04: bit 0 is timer 0 and bit 1 is timer 1. Timer 0 has its reload at 0x10 and its count at 0x14. Timer 1 has its reload at 0x18 and its count at 0x1C. A write takes effect at the clock edge, and a read returns data in the same cycle as the address.
- R3: An enabled counter whose value is not zero decreases by one per clock. A counter whose run bit is clear holds its value.
- R4: An enabled counter with auto-reload on that is at zero loads its reload value on the next clock. The period is therefore the reload value plus one clocks.
- R5: An enabled counter with auto-reload off that is at zero stays at zero, and on that clock its run bit in the control register clears.
- R6: The clock on which an enabled counter at zero would step sets that timer's status bit. The bit stays set, and each status bit drives its own interrupt output. The two timers do not affect each other.
- R7: Writing a one to a status bit clears it, and writing a zero leaves it unchanged. If an expiry and a clear land on the same clock, the expiry wins.
- R8: A write to a count register loads the write data on that clock. It overrides that clock's decrement, reload and expiry, so no flag is set.
- R9: Any offset other than the six listed reads zero, and writes to such offsets change nothing.
- R10: With the reload at all ones, a counter at zero wraps to 0xFFFFFFFF and continues counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one count tick |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq0 | output | 1 | Timer 0 expiry interrupt, sticky |
| irq1 | output | 1 | Timer 1 expiry interrupt, sticky |

## Verification
Any corruption of a count shows up at the count register's read port on the very next clock, because every tick changes a live value that is readable at once. A wrong expiry decision shows up one clock later in three places: the status bit, the interrupt pin, and either a missing reload or a run bit that has not been cleared. The bench therefore samples counts and flags on consecutive clocks around each expiry. It also places a flag clear and an overriding count write exactly on the expiry clock.

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq0,
  output logic              irq1
);
  localparam int NT = 2;
  localparam int CW = 2 * NT;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'('h10);

  logic [CW-1:0]           ctrl_q;
  logic [NT-1:0]           irq_q;
  logic [NT-1:0][CNT_W-1:0] cnt_q;
  logic [NT-1:0][CNT_W-1:0] rld_q;
  logic [NT-1:0]           wr_val, wr_rld, expire, stop;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_stat = wr_en && addr == A_STAT;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_RLD = A_BASE + ADDR_W'(8 * t);
    localparam logic [ADDR_W-1:0] A_VAL = A_RLD + ADDR_W'(4);
    assign wr_rld[t] = wr_en && addr == A_RLD;
    assign wr_val[t] = wr_en && addr == A_VAL;
    assign expire[t] = ctrl_q[2*t] && cnt_q[t] == '0 && !wr_val[t];
    assign stop[t]   = expire[t] && !ctrl_q[2*t+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (wr_rld[t]) rld_q[t] <= wdata;
        if (wr_val[t])
          cnt_q[t] <= wdata;
        else if (expire[t])
          cnt_q[t] <= ctrl_q[2*t+1] ? rld_q[t] : '0;
        else if (ctrl_q[2*t])
          cnt_q[t] <= cnt_q[t] - 1'b1;
      end
    end
  end

  logic [CW-1:0] stop_mask;
  always_comb begin
    stop_mask = '0;
    for (int t = 0; t < NT; t++) stop_mask[2*t] = stop[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= '0;
    end else begin
      ctrl_q <= wr_ctrl ? wdata[CW-1:0] : (ctrl_q & ~stop_mask);
      irq_q  <= (irq_q & ~(wr_stat ? wdata[NT-1:0] : '0)) | expire;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata[CW-1:0] = ctrl_q;
    else if (addr == A_STAT) rdata[NT-1:0] = irq_q;
    else
      for (int t = 0; t < NT; t++) begin
        if (addr == A_BASE + ADDR_W'(8 * t))     rdata = rld_q[t];
        if (addr == A_BASE + ADDR_W'(8 * t + 4)) rdata = cnt_q[t];
      end
  end

  assign irq0 = irq_q[0];
  assign irq1 = irq_q[1];
endmodule

// File: rtl/dual_reload_timer_chk.sv
module dual_reload_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  addr,
  input logic        wr_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        irq0,
  input logic        irq1,
  input logic [3:0]  ctrl,
  input logic [31:0] cnt0,
  input logic [31:0] cnt1,
  input logic [31:0] rld0
);
  wire wv0 = wr_en && addr == 8'h14;
  wire wv1 = wr_en && addr == 8'h1C;
  wire wc  = wr_en && addr == 8'h00;
  wire clr0 = wr_en && addr == 8'h04 && wdata[0];
  wire mapped = addr == 8'h00 || addr == 8'h04 || addr == 8'h10 ||
                addr == 8'h14 || addr == 8'h18 || addr == 8'h1C;

  AST_DECR_T0: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && cnt0 != 0 && !wv0 |=> cnt0 == $past(cnt0) - 1); // R3
  AST_HOLD_T1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] && !wv1 |=> $stable(cnt1)); // R3
  AST_RELOAD_T0: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && ctrl[1] && cnt0 == 0 && !wv0 |=> cnt0 == $past(rld0)); // R4
  AST_ONESHOT_STOP_T0: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && !ctrl[1] && cnt0 == 0 && !wv0 && !wc |=> !ctrl[0] && cnt0 == 0); // R5
  AST_EXPIRY_FLAG_T1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[2] && cnt1 == 0 && !wv1 |=> irq1); // R6
  AST_FLAG_STICKY_T0: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 && !clr0 |=> irq0); // R7
  AST_VAL_WRITE_T1: assert property (@(posedge clk) disable iff (!rst_n)
    wv1 |=> cnt1 == $past(wdata)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> rdata == 0); // R9
endmodule

bind dual_reload_timer dual_reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .irq0(irq0), .irq1(irq1), .ctrl(ctrl_q),
  .cnt0(cnt_q[0]), .cnt1(cnt_q[1]), .rld0(rld_q[0])
);

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq0, irq1;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_reload_timer u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq0(irq0), .irq1(irq1));

  localparam logic [71:0] VEC [8] = '{
    {8'h10, 32'h12345678, 32'h12345678},
    {8'h18, 32'h0BADF00D, 32'h0BADF00D},
    {8'h14, 32'h000000A5, 32'h000000A5},
    {8'h1C, 32'h00000077, 32'h00000077},
    {8'h00, 32'h0000000A, 32'h0000000A},
    {8'h00, 32'hFFFFFFF0, 32'h00000000},
    {8'h08, 32'hFFFFFFFF, 32'h00000000},
    {8'h24, 32'h12121212, 32'h00000000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    // R1 reset state
    foreach (VEC[i]) rd("R1", VEC[i][71:64], 32'h0);
    rd("R1", 8'h04, 0);
    chk("R1 irq", {30'b0, irq1, irq0}, 0);
    // R2 R9 table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd("R2/R9 table", VEC[i][71:64], VEC[i][31:0]);
    end
    rd("R9 no side effect", 8'h10, 32'h12345678);
    rd("R3 disabled hold", 8'h14, 32'h000000A5);
    rd("R3 disabled hold", 8'h1C, 32'h00000077);
    // R5 R6 one-shot timer 0
    wr(8'h14, 5);
    wr(8'h00, 32'h1);
    rd("R3", 8'h14, 5);
    step(1); rd("R3", 8'h14, 4);
    step(3); rd("R3", 8'h14, 1);
    step(1); rd("R3", 8'h14, 0);
    chk("R6 no early irq", irq0, 0);
    rd("R5 still running", 8'h00, 1);
    step(1);
    chk("R6 irq0", irq0, 1);
    rd("R5 run bit cleared", 8'h00, 0);
    rd("R5 stays zero", 8'h14, 0);
    step(2);
    rd("R5 stays zero", 8'h14, 0);
    chk("R6 sticky", irq0, 1);
    chk("R6 independent", irq1, 0);
    // R7 clear
    wr(8'h04, 32'h2);
    chk("R7 zero bit no clear", irq0, 1);
    wr(8'h04, 32'h1);
    chk("R7 clear", irq0, 0);
    rd("R7 status", 8'h04, 0);
    // R4 periodic timer 1
    wr(8'h18, 2);
    wr(8'h1C, 2);
    wr(8'h00, 32'hC);
    rd("R4", 8'h1C, 2);
    step(1); rd("R4", 8'h1C, 1);
    step(1); rd("R4", 8'h1C, 0);
    chk("R4 no early irq", irq1, 0);
    step(1); rd("R4 reload", 8'h1C, 2);
    chk("R6 irq1", irq1, 1);
    rd("R6 status", 8'h04, 2);
    rd("R4 run bit kept", 8'h00, 32'hC);
    chk("R6 independent", irq0, 0);
    step(1); rd("R4", 8'h1C, 1);
    step(1); rd("R4", 8'h1C, 0);
    // R7 clear on expiry clock: set wins
    wr(8'h04, 32'h2);
    rd("R4 period", 8'h1C, 2);
    chk("R7 set wins", irq1, 1);
    wr(8'h04, 32'h2);
    chk("R7 clear", irq1, 0);
    rd("R3", 8'h1C, 1);
    // R8 write priority
    wr(8'h1C, 32'h40);
    rd("R8 over decrement", 8'h1C, 32'h40);
    step(1); rd("R8", 8'h1C, 32'h3F);
    wr(8'h1C, 0);
    rd("R8", 8'h1C, 0);
    wr(8'h1C, 9);
    rd("R8 over reload", 8'h1C, 9);
    chk("R8 no expiry", irq1, 0);
    wr(8'h00, 0);
    // R10 wrap
    wr(8'h10, 32'hFFFFFFFF);
    wr(8'h14, 1);
    wr(8'h00, 32'h3);
    rd("R10", 8'h14, 1);
    step(1); rd("R10", 8'h14, 0);
    step(1); rd("R10 wrap", 8'h14, 32'hFFFFFFFF);
    chk("R10 irq", irq0, 1);
    step(1); rd("R10", 8'h14, 32'hFFFFFFFE);
    wr(8'h00, 0);
    rd("R3", 8'h14, 32'hFFFFFFFD);
    step(3); rd("R3 hold", 8'h14, 32'hFFFFFFFD);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule